// File: doc/BRIEF.md
# Interrupt Status Collector with Bus-State Timers

This block gathers the eight interrupt causes of a USB device controller into one status byte. It applies a per-bit enable mask and drives a single interrupt pin whose active level software selects. Six of the causes come from the endpoint and setup logic as levels, so each status bit simply follows its source. The other two come from timers inside the block that watch the bus line state. One timer measures how long SE0 lasts and reports a bus reset. The other measures how long the bus stays idle and reports a suspend.

The local controller reaches the block through a small register port: an enable byte, the status byte and a polarity bit. Both timers run on a microsecond scale derived from the system clock, so the thresholds are given in microseconds. The default thresholds are 2500 us for a bus reset and 3000 us for a suspend.

Top module: `usb_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: bit0 setup ready, bit1 EP1 packet ready, bit2 EP2 packet ready, bit3 EP0 receive ready, bit4 EP0 transmit ready, bit5 bus reset, bit6 suspend, bit7 EP3 packet ready.
- R2: The interrupt is active exactly when at least one status bit is 1 and its enable bit (same position, register address 0) is 1.
- R3: After `line_se0` has been sampled high on RESET_US*CLK_PER_US consecutive rising edges, a bus reset is detected. Any edge that samples it low restarts the count. Status bit5 is 1 from the next edge on.
- R4: If enable bit5 is 0 on the edge where a bus reset is detected, status bit5 is not set. Enabling bit5 later during the same SE0 period does not set it either.
- R5: Status bit5 stays 1 until a write to address 1 with data bit5 = 1 clears it. A new detection on the same edge takes priority over the clear.
- R6: Status bit6 is 1 from one edge after `line_idle` has been sampled high on SUSPEND_US*CLK_PER_US consecutive edges. It returns to 0 one edge after `line_idle` is sampled low, or one edge after a bus reset is being detected.
- R7: Register address 2, bit0 selects the pin polarity: 1 drives `irq_pin` high when the interrupt is active, 0 drives it low when active. The polarity takes effect on the edge after the write.
- R8: After reset the enable byte, the status byte and the polarity bit are all 0, so `irq_pin` rests high.
- R9: Status bits 0 to 4 and 7 equal the level of their source input as sampled on the previous rising edge.
- R10: Reads return the enable byte at address 0, the status byte at address 1, the polarity in bit0 at address 2 (other bits 0), and 0 at address 3. Writes to address 1 change only bit5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_se0 | input | 1 | Bus is in the single-ended-zero state |
| line_idle | input | 1 | Bus is in the idle state |
| setup_rdy | input | 1 | Setup data ready level |
| ep0_rx_rdy | input | 1 | EP0 receive packet ready level |
| ep0_tx_rdy | input | 1 | EP0 transmit packet ready level |
| ep1_rdy | input | 1 | EP1 packet ready level |
| ep2_rdy | input | 1 | EP2 packet ready level |
| ep3_rdy | input | 1 | EP3 packet ready level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| irq_pin | output | 1 | Interrupt output, level set by the polarity bit |

## Verification
Each endpoint status bit is due one rising edge after its source changes. A timer result lands one edge after the edge that samples the last qualifying line cycle, and a timer result falls one edge after the line leaves that state. The pin and the read data follow the registered state within the same cycle. A write to the enable or polarity register is therefore visible right after its own edge. The bench keeps a behavioural model that advances on every rising edge with the same sampled inputs. It compares the read data and the pin 1 ns after each edge, once every register stage is settled, and never near the edge where inputs change. Directed probes add tag-named checks at the SE0 and idle run lengths one short of the threshold, exactly at the threshold, and with a one-cycle break in the run.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int NUM_SRC = 8;
    localparam int NUM_TMR = 2;

    // status bit positions
    localparam int BIT_SETUP  = 0;
    localparam int BIT_EP1    = 1;
    localparam int BIT_EP2    = 2;
    localparam int BIT_EP0RX  = 3;
    localparam int BIT_EP0TX  = 4;
    localparam int BIT_BUSRST = 5;
    localparam int BIT_SUSP   = 6;
    localparam int BIT_EP3    = 7;

    // timer slots
    localparam int TMR_SE0  = 0;
    localparam int TMR_IDLE = 1;

    typedef logic [NUM_SRC-1:0] irq_vec_t;

    typedef enum logic [1:0] {
        ADDR_ENABLE   = 2'd0,
        ADDR_STATUS   = 2'd1,
        ADDR_POLARITY = 2'd2,
        ADDR_SPARE    = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/line_dur_timer.sv
module line_dur_timer #(
    parameter int CYC_PER_US = 48,
    parameter int LIMIT_US   = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic held,
    output logic fired
);
    localparam int PW = $clog2(CYC_PER_US + 1);
    localparam int UW = $clog2(LIMIT_US + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
    localparam logic [UW-1:0] US_LAST  = UW'(LIMIT_US);
    localparam logic [UW-1:0] US_PRE   = UW'(LIMIT_US - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [UW-1:0] us;
        logic          fire;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.fire = 1'b0;
        if (!cond) begin
            t_d.pre = '0;
            t_d.us  = '0;
        end else if (t_q.pre == PRE_LAST) begin
            t_d.pre = '0;
            if (t_q.us != US_LAST) begin
                t_d.us = t_q.us + 1'b1;
            end
            if (t_q.us == US_PRE) begin
                t_d.fire = 1'b1;
            end
        end else begin
            t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign held  = (t_q.us == US_LAST);
    assign fired = t_q.fire;

    AST_HELD_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !held); // R3
    AST_FIRE_WITH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> held); // R3
    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fired |=> !fired); // R3

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import usb_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t ep_level,
    input  logic     rst_fire,
    input  logic     rst_held,
    input  logic     rst_en,
    input  logic     rst_clr,
    input  logic     idle_fire,
    input  logic     idle_held,
    output irq_vec_t status
);
    localparam irq_vec_t EP_MASK =
        ~(irq_vec_t'(1) << BIT_BUSRST) & ~(irq_vec_t'(1) << BIT_SUSP);

    typedef struct packed {
        irq_vec_t stat;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d.stat = ep_level & EP_MASK;
        // bus reset: set only when enabled at detection; set beats clear
        if (rst_fire && rst_en) begin
            s_d.stat[BIT_BUSRST] = 1'b1;
        end else if (rst_clr) begin
            s_d.stat[BIT_BUSRST] = 1'b0;
        end else begin
            s_d.stat[BIT_BUSRST] = s_q.stat[BIT_BUSRST];
        end
        // suspend: held while idle persists, dropped on activity or reset
        s_d.stat[BIT_SUSP] = (s_q.stat[BIT_SUSP] | idle_fire) & idle_held & ~rst_held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.stat;

    AST_BUSRST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[BIT_BUSRST] && !rst_en) |=> !status[BIT_BUSRST]); // R4
    AST_BUSRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_BUSRST] && !rst_clr) |=> status[BIT_BUSRST]); // R5
    AST_SUSP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_held |=> !status[BIT_SUSP]); // R6
    AST_EP1_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ep_level[BIT_EP1] |=> status[BIT_EP1]); // R9

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import usb_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  irq_vec_t   status,
    output irq_vec_t   enable,
    output logic       polarity,
    output logic       busrst_clr,
    output logic [7:0] rdata
);
    typedef struct packed {
        irq_vec_t en;
        logic     pol;
    } regs_t;

    regs_t r_d, r_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(addr);

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (sel)
                ADDR_ENABLE:   r_d.en  = wdata;
                ADDR_POLARITY: r_d.pol = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (sel)
            ADDR_ENABLE:   rdata = r_q.en;
            ADDR_STATUS:   rdata = status;
            ADDR_POLARITY: rdata = {7'b0, r_q.pol};
            default:       rdata = 8'h00;
        endcase
    end

    assign busrst_clr = wr && (sel == ADDR_STATUS) && wdata[BIT_BUSRST];
    assign enable     = r_q.en;
    assign polarity   = r_q.pol;

    AST_POL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == ADDR_POLARITY) |=> (polarity == $past(wdata[0]))); // R7
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(enable)); // R10

endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int CLK_PER_US = 48,
    parameter int RESET_US   = 2500,
    parameter int SUSPEND_US = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_se0,
    input  logic       line_idle,
    input  logic       setup_rdy,
    input  logic       ep0_rx_rdy,
    input  logic       ep0_tx_rdy,
    input  logic       ep1_rdy,
    input  logic       ep2_rdy,
    input  logic       ep3_rdy,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_pin
);
    logic [NUM_TMR-1:0] line_cond;
    logic [NUM_TMR-1:0] tmr_held;
    logic [NUM_TMR-1:0] tmr_fired;
    irq_vec_t           ep_level;
    irq_vec_t           status;
    irq_vec_t           enable;
    logic               polarity;
    logic               busrst_clr;
    logic               irq_any;

    assign line_cond[TMR_SE0]  = line_se0;
    assign line_cond[TMR_IDLE] = line_idle;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        localparam int LIM = (g == TMR_SE0) ? RESET_US : SUSPEND_US;
        line_dur_timer #(
            .CYC_PER_US (CLK_PER_US),
            .LIMIT_US   (LIM)
        ) i_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (line_cond[g]),
            .held  (tmr_held[g]),
            .fired (tmr_fired[g])
        );
    end

    always_comb begin
        ep_level             = '0;
        ep_level[BIT_SETUP]  = setup_rdy;
        ep_level[BIT_EP1]    = ep1_rdy;
        ep_level[BIT_EP2]    = ep2_rdy;
        ep_level[BIT_EP0RX]  = ep0_rx_rdy;
        ep_level[BIT_EP0TX]  = ep0_tx_rdy;
        ep_level[BIT_EP3]    = ep3_rdy;
    end

    irq_status_bank i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ep_level  (ep_level),
        .rst_fire  (tmr_fired[TMR_SE0]),
        .rst_held  (tmr_held[TMR_SE0]),
        .rst_en    (enable[BIT_BUSRST]),
        .rst_clr   (busrst_clr),
        .idle_fire (tmr_fired[TMR_IDLE]),
        .idle_held (tmr_held[TMR_IDLE]),
        .status    (status)
    );

    irq_reg_port i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status     (status),
        .enable     (enable),
        .polarity   (polarity),
        .busrst_clr (busrst_clr),
        .rdata      (reg_rdata)
    );

    assign irq_any = |(status & enable);
    assign irq_pin = polarity ? irq_any : ~irq_any;

    AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> (irq_pin == !polarity)); // R2
    AST_SUSP_NOT_IN_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_held[TMR_SE0] |=> !status[BIT_SUSP]); // R6

endmodule

// File: tb/test_usb_irq_ctrl.sv
`timescale 1ns/1ps
module test_usb_irq_ctrl;
    localparam int P    = 4;
    localparam int RUS  = 10;
    localparam int SUS  = 12;
    localparam int NSE0 = RUS * P;
    localparam int NIDL = SUS * P;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_se0 = 1'b0, line_idle = 1'b0;
    logic       setup_rdy = 1'b0, ep0_rx_rdy = 1'b0, ep0_tx_rdy = 1'b0;
    logic       ep1_rdy = 1'b0, ep2_rdy = 1'b0, ep3_rdy = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd1;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_pin;

    always #2.5 clk = ~clk;

    usb_irq_ctrl #(.CLK_PER_US(P), .RESET_US(RUS), .SUSPEND_US(SUS)) i_usb_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .line_se0(line_se0), .line_idle(line_idle),
        .setup_rdy(setup_rdy), .ep0_rx_rdy(ep0_rx_rdy), .ep0_tx_rdy(ep0_tx_rdy),
        .ep1_rdy(ep1_rdy), .ep2_rdy(ep2_rdy), .ep3_rdy(ep3_rdy),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pin(irq_pin)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R8";

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_stat = 8'h00, m_en = 8'h00;
    logic       m_pol = 1'b0;
    int         se_run = 0, id_run = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 8'h00; m_en = 8'h00; m_pol = 1'b0; se_run = 0; id_run = 0;
        end else begin
            logic [7:0] ns;
            ns    = 8'h00;
            ns[0] = setup_rdy; ns[1] = ep1_rdy; ns[2] = ep2_rdy;
            ns[3] = ep0_rx_rdy; ns[4] = ep0_tx_rdy; ns[7] = ep3_rdy;
            if (se_run == NSE0 && m_en[5]) ns[5] = 1'b1;
            else if (reg_wr && reg_addr == 2'd1 && reg_wdata[5]) ns[5] = 1'b0;
            else ns[5] = m_stat[5];
            ns[6] = (id_run >= NIDL) && !(se_run >= NSE0);
            m_stat = ns;
            if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_pol = reg_wdata[0];
            se_run = line_se0  ? ((se_run > NSE0) ? se_run : se_run + 1) : 0;
            id_run = line_idle ? ((id_run > NIDL) ? id_run : id_run + 1) : 0;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [7:0] er;
            logic       any;
            case (reg_addr)
                2'd0: er = m_en;
                2'd1: er = m_stat;
                2'd2: er = {7'b0, m_pol};
                default: er = 8'h00;
            endcase
            any = |(m_stat & m_en);
            check(cur_req, reg_rdata, er);
            check(cur_req, {7'b0, irq_pin}, {7'b0, m_pol ? any : !any});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic peek(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        #1;
        check(req, reg_rdata, exp);
        @(negedge clk);
        reg_addr = 2'd1;
    endtask

    task automatic pin_is(input string req, input logic exp);
        @(posedge clk);
        #1;
        check(req, {7'b0, irq_pin}, {7'b0, exp});
    endtask

    task automatic run_se0(input int n);
        @(negedge clk); line_se0 = 1'b1;
        cyc(n);
        line_se0 = 1'b0;
    endtask

    task automatic run_idle(input int n);
        @(negedge clk); line_idle = 1'b1;
        cyc(n);
        line_idle = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R8 reset state
        cur_req = "R8";
        peek("R8", 2'd0, 8'h00);
        peek("R8", 2'd1, 8'h00);
        peek("R8", 2'd2, 8'h00);
        pin_is("R8", 1'b1);
        cur_req = "R10";
        peek("R10", 2'd3, 8'h00);

        // R9 / R1 source levels and bit map
        cur_req = "R9";
        @(negedge clk); ep1_rdy = 1'b1;
        peek("R1", 2'd1, 8'h02);
        @(negedge clk); ep3_rdy = 1'b1;
        peek("R1", 2'd1, 8'h82);
        @(negedge clk); setup_rdy = 1'b1;
        peek("R1", 2'd1, 8'h83);
        @(negedge clk); ep0_rx_rdy = 1'b1;
        peek("R1", 2'd1, 8'h8B);
        @(negedge clk); ep0_tx_rdy = 1'b1; ep2_rdy = 1'b1;
        peek("R9", 2'd1, 8'h9F);
        @(negedge clk);
        setup_rdy = 1'b0; ep0_rx_rdy = 1'b0; ep0_tx_rdy = 1'b0;
        ep1_rdy = 1'b0; ep2_rdy = 1'b0; ep3_rdy = 1'b0;
        peek("R9", 2'd1, 8'h00);

        // R2 masking
        cur_req = "R2";
        wr(2'd0, 8'h02);
        @(negedge clk); ep2_rdy = 1'b1;
        cyc(2);
        pin_is("R2", 1'b1);
        @(negedge clk); ep1_rdy = 1'b1;
        cyc(2);
        pin_is("R2", 1'b0);

        // R7 polarity
        cur_req = "R7";
        wr(2'd2, 8'h01);
        pin_is("R7", 1'b1);
        peek("R7", 2'd2, 8'h01);
        wr(2'd2, 8'hFE);
        peek("R7", 2'd2, 8'h00);
        pin_is("R7", 1'b0);
        wr(2'd2, 8'h01);

        // R10 status writes ignored except bit5
        cur_req = "R10";
        @(negedge clk); ep2_rdy = 1'b0;
        wr(2'd1, 8'hDF);
        peek("R10", 2'd1, 8'h02);
        wr(2'd0, 8'h5A);
        peek("R10", 2'd0, 8'h5A);
        @(negedge clk); ep1_rdy = 1'b0;

        // R4 bus reset masked by enable
        cur_req = "R4";
        wr(2'd0, 8'h00);
        @(negedge clk); line_se0 = 1'b1;
        cyc(NSE0 + 10);
        peek("R4", 2'd1, 8'h00);
        wr(2'd0, 8'h20);
        cyc(10);
        peek("R4", 2'd1, 8'h00);
        @(negedge clk); line_se0 = 1'b0;
        cyc(3);

        // R3 thresholds
        cur_req = "R3";
        run_se0(NSE0 - 1);
        cyc(4);
        peek("R3", 2'd1, 8'h00);
        run_se0(NSE0 - 5);
        run_se0(10);
        cyc(4);
        peek("R3", 2'd1, 8'h00);
        run_se0(NSE0);
        cyc(3);
        peek("R3", 2'd1, 8'h20);
        pin_is("R3", 1'b1);

        // R5 sticky until write-one clear
        cur_req = "R5";
        cyc(6);
        peek("R5", 2'd1, 8'h20);
        wr(2'd1, 8'h20);
        peek("R5", 2'd1, 8'h00);
        pin_is("R5", 1'b0);

        // R6 suspend
        cur_req = "R6";
        wr(2'd0, 8'h60);
        run_idle(NIDL - 1);
        cyc(3);
        peek("R6", 2'd1, 8'h00);
        @(negedge clk); line_idle = 1'b1;
        cyc(NIDL + 2);
        peek("R6", 2'd1, 8'h40);
        pin_is("R6", 1'b1);
        @(negedge clk); line_idle = 1'b0;
        cyc(1);
        peek("R6", 2'd1, 8'h00);
        @(negedge clk); line_idle = 1'b1;
        cyc(NIDL + 3);
        peek("R6", 2'd1, 8'h40);
        @(negedge clk); line_se0 = 1'b1;
        cyc(NSE0 + 5);
        peek("R6", 2'd1, 8'h20);
        @(negedge clk); line_se0 = 1'b0; line_idle = 1'b0;
        wr(2'd1, 8'h20);
        peek("R6", 2'd1, 8'h00);

        cyc(4);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule